// File: doc/BRIEF.md
# JTAG-driven AXI4 single-beat channel bridge

This block lets a debug probe act as an AXI4 manager by shifting bit strings through a JTAG test access port. The 4-bit instruction register picks one of five data registers per manager port. Three are request registers: write address, write data and read address. Two are response registers: write response and read data. Two manager ports are provided: port 0 for control traffic and port 1 for data traffic. An instruction offset of five per port selects between them.

The TAP pins are oversampled in the system clock domain, so every shift, capture and update is a single-cycle strobe in that domain. An Update-DR on a request register presents its contents on the matching AXI channel with valid raised, and holds them until ready. Each response channel has a one-entry holding register that accepts one beat. A later Capture-DR on that channel's register reads the beat out and frees the entry.

Top module: `jtag_axi_bridge`

## Requirements
- R1: The instruction register is 4 bits wide and shifted LSB first. Capture-IR loads 4'b0001, and Update-IR makes the shifted value the current instruction.
- R2: Reset and the Test-Logic-Reset state load instruction 4'b1111. Every code at or above 5*NPORT (10 to 15 by default) selects a 1-bit bypass register. That register captures 0 and delays the serial input by one TCK.
- R3: Code 5*p+c selects channel c of port p. The channels are c=0 write address, c=1 write data, c=2 write response, c=3 read address and c=4 read data. Port 0 is the control port and port 1 is the data port.
- R4: A data register takes serial input at its MSB and shifts toward bit 0. The serial output presents bit 0 and changes only after a falling TCK edge, so the first bit read is bit 0 of the captured value.
- R5: The write and read address payloads are, MSB to LSB: address, len(8), size(3), burst(2), cache(4), prot(3), qos(4), region(4), id, user. Port p occupies slice [p*width +: width] of the bits bus.
- R6: The write data payload is, MSB to LSB: data, last(1), id, strobe(DATA_W/8), user.
- R7: Update-DR on a request register with no pending beat raises that channel's valid. The payload then equals the shifted value and stays stable until ready.
- R8: Update-DR on a request register whose valid is still high has no effect on its payload or valid.
- R9: Valid drops in the clock after a cycle where valid and ready are both high.
- R10: A response channel holds ready high while its entry is empty, accepts one beat on valid and ready, and holds ready low until the next Capture-DR of that channel.
- R11: Capture-DR of a full response entry loads {1, resp(2), id, user} for write response, or {1, resp(2), data, last, id, user} for read data, and empties the entry.
- R12: Capture-DR of an empty response entry loads all zeros, so the leading valid bit reads 0.
- R13: After reset no request valid is high. Entering Test-Logic-Reset drops every pending request valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_clk | input | 1 | Test clock, oversampled |
| tap_mode | input | 1 | Test mode select |
| tap_din | input | 1 | Serial test data in |
| tap_dout | output | 1 | Serial test data out |
| m_aw_valid | output | NPORT | Write address valid per port |
| m_aw_ready | input | NPORT | Write address ready per port |
| m_aw_bits | output | NPORT*AW_W | Write address payloads (R5 layout) |
| m_w_valid | output | NPORT | Write data valid per port |
| m_w_ready | input | NPORT | Write data ready per port |
| m_w_bits | output | NPORT*W_W | Write data payloads (R6 layout) |
| m_ar_valid | output | NPORT | Read address valid per port |
| m_ar_ready | input | NPORT | Read address ready per port |
| m_ar_bits | output | NPORT*AW_W | Read address payloads (R5 layout) |
| m_b_valid | input | NPORT | Write response valid per port |
| m_b_ready | output | NPORT | Write response ready per port |
| m_b_bits | input | NPORT*B_W | Write responses {resp, id, user} |
| m_r_valid | input | NPORT | Read data valid per port |
| m_r_ready | output | NPORT | Read data ready per port |
| m_r_bits | input | NPORT*R_W | Read data {resp, data, last, id, user} |

## Verification
The properties assume the TAP pins change slowly next to the system clock: each TCK level lasts several clock cycles, and TMS and TDI change only while TCK is low, so the synchronised copies line up. The bench holds each TCK phase for eight clocks and drives TMS and TDI at the start of the low phase. It also raises response valids only for a single clock and only while ready is high, so the properties never have to reason about a dropped beat. Request ready is pulsed for one clock at a time, which allows the stall and ignored-update cases to be observed on the payload ports.

// File: rtl/jtag_axi_pkg.sv
package jtag_axi_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  // channel slots per manager port, in instruction order
  localparam int CHANS = 5;
  localparam int CH_AW = 0;
  localparam int CH_W  = 1;
  localparam int CH_B  = 2;
  localparam int CH_AR = 3;
  localparam int CH_R  = 4;

  localparam int LEN_W    = 8;
  localparam int SIZE_W   = 3;
  localparam int BURST_W  = 2;
  localparam int CACHE_W  = 4;
  localparam int PROT_W   = 3;
  localparam int QOS_W    = 4;
  localparam int REGION_W = 4;
  localparam int RESP_W   = 2;

  function automatic int aw_width(input int addr_w, input int id_w, input int user_w);
    return addr_w + LEN_W + SIZE_W + BURST_W + CACHE_W + PROT_W + QOS_W + REGION_W + id_w + user_w;
  endfunction

  function automatic int w_width(input int data_w, input int id_w, input int user_w);
    return data_w + 1 + id_w + data_w / 8 + user_w;
  endfunction

  function automatic int b_width(input int id_w, input int user_w);
    return RESP_W + id_w + user_w;
  endfunction

  function automatic int r_width(input int data_w, input int id_w, input int user_w);
    return RESP_W + data_w + 1 + id_w + user_w;
  endfunction

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      TS_RESET:    n = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   n = tms ? TS_SEL_DR   : TS_IDLE;
      default:     n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jtag_axi_tap.sv
// Oversampling TAP controller: synchronises the pins into clk, runs the
// state machine on each detected rising test-clock edge and owns the IR.
module jtag_axi_tap
  import jtag_axi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  output tap_state_e      state,
  output logic [IR_W-1:0] ir,
  output logic            ir_lsb,
  output logic            tdi_s,
  output logic            tck_fall,
  output logic            cap_dr,
  output logic            shift_dr,
  output logic            upd_dr
);

  logic [SYNC_STAGES:0]   tck_sr;
  logic [SYNC_STAGES-1:0] tms_sr;
  logic [SYNC_STAGES-1:0] tdi_sr;
  logic [IR_W-1:0]        ir_sr;
  logic                   tck_rise;
  logic                   tms_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      tck_sr <= '0;
      tms_sr <= '1;
      tdi_sr <= '0;
    end else begin
      tck_sr <= {tck_sr[SYNC_STAGES-1:0], tck};
      tms_sr <= {tms_sr[SYNC_STAGES-2:0], tms};
      tdi_sr <= {tdi_sr[SYNC_STAGES-2:0], tdi};
    end
  end

  assign tck_rise = tck_sr[SYNC_STAGES-1] & ~tck_sr[SYNC_STAGES];
  assign tck_fall = ~tck_sr[SYNC_STAGES-1] & tck_sr[SYNC_STAGES];
  assign tms_s    = tms_sr[SYNC_STAGES-1];
  assign tdi_s    = tdi_sr[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TS_RESET;
      ir    <= IR_BYPASS;
      ir_sr <= '0;
    end else begin
      if (tck_rise) begin
        state <= tap_next(state, tms_s);
        case (state)
          TS_CAP_IR:   ir_sr <= IR_CAPTURE;
          TS_SHIFT_IR: ir_sr <= {tdi_s, ir_sr[IR_W-1:1]};
          TS_UPD_IR:   ir    <= ir_sr;
          default:     ;
        endcase
      end
      if (state == TS_RESET) ir <= IR_BYPASS;
    end
  end

  assign ir_lsb   = ir_sr[0];
  assign cap_dr   = tck_rise && (state == TS_CAP_DR);
  assign shift_dr = tck_rise && (state == TS_SHIFT_DR);
  assign upd_dr   = tck_rise && (state == TS_UPD_DR);

endmodule

// File: rtl/jtag_axi_req_dr.sv
// Request data register: shift stage plus a held AXI payload with valid.
module jtag_axi_req_dr #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         sel,
  input  logic         cap,
  input  logic         shf,
  input  logic         upd,
  input  logic         tdi,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] bits,
  output logic         lsb
);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      bits  <= '0;
      valid <= 1'b0;
    end else begin
      if (sel && cap)      sr <= bits;
      else if (sel && shf) sr <= {tdi, sr[W-1:1]};

      if (clear)                     valid <= 1'b0;
      else if (valid && ready)       valid <= 1'b0;
      else if (!valid && sel && upd) begin
        valid <= 1'b1;
        bits  <= sr;
      end
    end
  end

  assign lsb = sr[0];

endmodule

// File: rtl/jtag_axi_rsp_dr.sv
// Response data register: one-entry holding stage read out by Capture-DR.
module jtag_axi_rsp_dr #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         cap,
  input  logic         shf,
  input  logic         tdi,
  input  logic         in_valid,
  input  logic [W-1:0] in_bits,
  output logic         in_ready,
  output logic         lsb
);

  logic         full;
  logic [W-1:0] hold;
  logic [W:0]   sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      hold <= '0;
      sr   <= '0;
    end else begin
      if (sel && cap)      sr <= full ? {1'b1, hold} : '0;
      else if (sel && shf) sr <= {tdi, sr[W:1]};

      if (in_valid && !full) begin
        full <= 1'b1;
        hold <= in_bits;
      end else if (sel && cap) begin
        full <= 1'b0;
      end
    end
  end

  assign in_ready = ~full;
  assign lsb      = sr[0];

endmodule

// File: rtl/jtag_axi_bridge.sv
module jtag_axi_bridge
  import jtag_axi_pkg::*;
#(
  parameter int NPORT  = 2,   // NPORT*CHANS must stay below 16
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int USER_W = 1
)(
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            tap_clk,
  input  logic                                            tap_mode,
  input  logic                                            tap_din,
  output logic                                            tap_dout,
  output logic [NPORT-1:0]                                m_aw_valid,
  input  logic [NPORT-1:0]                                m_aw_ready,
  output logic [NPORT*aw_width(ADDR_W, ID_W, USER_W)-1:0] m_aw_bits,
  output logic [NPORT-1:0]                                m_w_valid,
  input  logic [NPORT-1:0]                                m_w_ready,
  output logic [NPORT*w_width(DATA_W, ID_W, USER_W)-1:0]  m_w_bits,
  output logic [NPORT-1:0]                                m_ar_valid,
  input  logic [NPORT-1:0]                                m_ar_ready,
  output logic [NPORT*aw_width(ADDR_W, ID_W, USER_W)-1:0] m_ar_bits,
  input  logic [NPORT-1:0]                                m_b_valid,
  output logic [NPORT-1:0]                                m_b_ready,
  input  logic [NPORT*b_width(ID_W, USER_W)-1:0]          m_b_bits,
  input  logic [NPORT-1:0]                                m_r_valid,
  output logic [NPORT-1:0]                                m_r_ready,
  input  logic [NPORT*r_width(DATA_W, ID_W, USER_W)-1:0]  m_r_bits
);

  localparam int AW_W  = aw_width(ADDR_W, ID_W, USER_W);
  localparam int W_W   = w_width(DATA_W, ID_W, USER_W);
  localparam int B_W   = b_width(ID_W, USER_W);
  localparam int R_W   = r_width(DATA_W, ID_W, USER_W);
  localparam int NSLOT = NPORT * CHANS;

  tap_state_e      tap_st;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, tdi_s, tck_fall, cap_dr, shift_dr, upd_dr;
  logic            tap_clear;
  logic [NSLOT-1:0] sel, dr_lsb;
  logic            byp_sel, byp_q, dr_out;

  jtag_axi_tap u_tap (
    .clk      (clk),
    .rst      (rst),
    .tck      (tap_clk),
    .tms      (tap_mode),
    .tdi      (tap_din),
    .state    (tap_st),
    .ir       (ir_q),
    .ir_lsb   (ir_lsb),
    .tdi_s    (tdi_s),
    .tck_fall (tck_fall),
    .cap_dr   (cap_dr),
    .shift_dr (shift_dr),
    .upd_dr   (upd_dr)
  );

  assign tap_clear = (tap_st == TS_RESET);

  always_comb begin
    for (int i = 0; i < NSLOT; i++) sel[i] = (ir_q == IR_W'(i));
  end
  assign byp_sel = ~|sel;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int S = p * CHANS;

    jtag_axi_req_dr #(.W(AW_W)) u_aw (
      .clk(clk), .rst(rst), .clear(tap_clear), .sel(sel[S+CH_AW]),
      .cap(cap_dr), .shf(shift_dr), .upd(upd_dr), .tdi(tdi_s),
      .ready(m_aw_ready[p]), .valid(m_aw_valid[p]),
      .bits(m_aw_bits[p*AW_W +: AW_W]), .lsb(dr_lsb[S+CH_AW])
    );

    jtag_axi_req_dr #(.W(W_W)) u_w (
      .clk(clk), .rst(rst), .clear(tap_clear), .sel(sel[S+CH_W]),
      .cap(cap_dr), .shf(shift_dr), .upd(upd_dr), .tdi(tdi_s),
      .ready(m_w_ready[p]), .valid(m_w_valid[p]),
      .bits(m_w_bits[p*W_W +: W_W]), .lsb(dr_lsb[S+CH_W])
    );

    jtag_axi_req_dr #(.W(AW_W)) u_ar (
      .clk(clk), .rst(rst), .clear(tap_clear), .sel(sel[S+CH_AR]),
      .cap(cap_dr), .shf(shift_dr), .upd(upd_dr), .tdi(tdi_s),
      .ready(m_ar_ready[p]), .valid(m_ar_valid[p]),
      .bits(m_ar_bits[p*AW_W +: AW_W]), .lsb(dr_lsb[S+CH_AR])
    );

    jtag_axi_rsp_dr #(.W(B_W)) u_b (
      .clk(clk), .rst(rst), .sel(sel[S+CH_B]),
      .cap(cap_dr), .shf(shift_dr), .tdi(tdi_s),
      .in_valid(m_b_valid[p]), .in_bits(m_b_bits[p*B_W +: B_W]),
      .in_ready(m_b_ready[p]), .lsb(dr_lsb[S+CH_B])
    );

    jtag_axi_rsp_dr #(.W(R_W)) u_r (
      .clk(clk), .rst(rst), .sel(sel[S+CH_R]),
      .cap(cap_dr), .shf(shift_dr), .tdi(tdi_s),
      .in_valid(m_r_valid[p]), .in_bits(m_r_bits[p*R_W +: R_W]),
      .in_ready(m_r_ready[p]), .lsb(dr_lsb[S+CH_R])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                        byp_q <= 1'b0;
    else if (byp_sel && cap_dr)     byp_q <= 1'b0;
    else if (byp_sel && shift_dr)   byp_q <= tdi_s;
  end

  assign dr_out = byp_sel ? byp_q : |(sel & dr_lsb);

  always_ff @(posedge clk) begin
    if (rst) tap_dout <= 1'b0;
    else if (tck_fall) begin
      if (tap_st == TS_SHIFT_IR)      tap_dout <= ir_lsb;
      else if (tap_st == TS_SHIFT_DR) tap_dout <= dr_out;
      else                            tap_dout <= 1'b0;
    end
  end

endmodule

// File: rtl/jtag_axi_bridge_chk.sv
module jtag_axi_bridge_chk
  import jtag_axi_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int AW_W  = 8,
  parameter int W_W   = 8
)(
  input logic                  clk,
  input logic                  rst,
  input tap_state_e            tap_st,
  input logic [IR_W-1:0]       ir_q,
  input logic [NPORT-1:0]      aw_valid,
  input logic [NPORT-1:0]      aw_ready,
  input logic [NPORT*AW_W-1:0] aw_bits,
  input logic [NPORT-1:0]      w_valid,
  input logic [NPORT-1:0]      w_ready,
  input logic [NPORT*W_W-1:0]  w_bits,
  input logic [NPORT-1:0]      ar_valid,
  input logic [NPORT-1:0]      ar_ready,
  input logic [NPORT*AW_W-1:0] ar_bits,
  input logic [NPORT-1:0]      b_valid,
  input logic [NPORT-1:0]      b_ready,
  input logic [NPORT-1:0]      r_valid,
  input logic [NPORT-1:0]      r_ready
);

  // R13
  tlr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_st == TS_RESET) |=> (aw_valid == '0 && w_valid == '0 && ar_valid == '0));

  // R2
  tlr_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_st == TS_RESET) |=> (ir_q == IR_BYPASS));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R7
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (aw_valid[p] && !aw_ready[p] && tap_st != TS_RESET)
        |=> (aw_valid[p] && $stable(aw_bits[p*AW_W +: AW_W])));
    // R7
    w_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (w_valid[p] && !w_ready[p] && tap_st != TS_RESET)
        |=> (w_valid[p] && $stable(w_bits[p*W_W +: W_W])));
    // R7
    ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ar_valid[p] && !ar_ready[p] && tap_st != TS_RESET)
        |=> (ar_valid[p] && $stable(ar_bits[p*AW_W +: AW_W])));
    // R3
    aw_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(aw_valid[p]) |-> ($past(tap_st) == TS_UPD_DR && $past(ir_q) == IR_W'(p*CHANS+CH_AW)));
    // R9
    aw_drop_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(aw_valid[p]) |-> ($past(aw_ready[p]) || $past(tap_st) == TS_RESET));
    // R10
    b_fill_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(b_ready[p]) |-> $past(b_valid[p]));
    // R10
    r_fill_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(r_ready[p]) |-> $past(r_valid[p]));
  end

endmodule

bind jtag_axi_bridge jtag_axi_bridge_chk #(
  .NPORT(NPORT), .AW_W(AW_W), .W_W(W_W)
) u_chk (
  .clk(clk), .rst(rst), .tap_st(tap_st), .ir_q(ir_q),
  .aw_valid(m_aw_valid), .aw_ready(m_aw_ready), .aw_bits(m_aw_bits),
  .w_valid(m_w_valid), .w_ready(m_w_ready), .w_bits(m_w_bits),
  .ar_valid(m_ar_valid), .ar_ready(m_ar_ready), .ar_bits(m_ar_bits),
  .b_valid(m_b_valid), .b_ready(m_b_ready),
  .r_valid(m_r_valid), .r_ready(m_r_ready)
);

// File: tb/test_jtag_axi_bridge.sv
module test_jtag_axi_bridge;
  import jtag_axi_pkg::*;

  localparam int NP   = 2;
  localparam int AW_W = 65;   // 32 addr + 28 fixed fields + 4 id + 1 user
  localparam int W_W  = 42;   // 32 data + last + 4 id + 4 strobe + 1 user
  localparam int B_W  = 7;    // 2 resp + 4 id + 1 user
  localparam int R_W  = 40;   // 2 resp + 32 data + last + 4 id + 1 user

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, tdo;
  logic [NP-1:0] aw_valid, aw_ready = '0, w_valid, w_ready = '0, ar_valid, ar_ready = '0;
  logic [NP*AW_W-1:0] aw_bits, ar_bits;
  logic [NP*W_W-1:0]  w_bits;
  logic [NP-1:0] b_valid = '0, b_ready, r_valid = '0, r_ready;
  logic [NP*B_W-1:0] b_bits = '0;
  logic [NP*R_W-1:0] r_bits = '0;

  int checks = 0;
  int errors = 0;
  logic so;

  // behavioural model of what each request channel should be presenting
  logic [127:0] m_aw [NP];
  logic [127:0] m_w  [NP];
  logic [127:0] m_ar [NP];

  always #5 clk = ~clk;

  jtag_axi_bridge i_jtag_axi_bridge (
    .clk(clk), .rst(rst),
    .tap_clk(tck), .tap_mode(tms), .tap_din(tdi), .tap_dout(tdo),
    .m_aw_valid(aw_valid), .m_aw_ready(aw_ready), .m_aw_bits(aw_bits),
    .m_w_valid(w_valid), .m_w_ready(w_ready), .m_w_bits(w_bits),
    .m_ar_valid(ar_valid), .m_ar_ready(ar_ready), .m_ar_bits(ar_bits),
    .m_b_valid(b_valid), .m_b_ready(b_ready), .m_b_bits(b_bits),
    .m_r_valid(r_valid), .m_r_ready(r_ready), .m_r_bits(r_bits)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every clock: a presented payload must match the model (R7, R8)
  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < NP; p++) begin
        if (aw_valid[p]) chk("R7 aw payload", 128'(aw_bits[p*AW_W +: AW_W]), m_aw[p]);
        if (w_valid[p])  chk("R7 w payload",  128'(w_bits[p*W_W +: W_W]),   m_w[p]);
        if (ar_valid[p]) chk("R7 ar payload", 128'(ar_bits[p*AW_W +: AW_W]), m_ar[p]);
      end
    end
  end

  function automatic logic [127:0] mk_addr(input logic [31:0] a, input logic [3:0] id, input logic u);
    return 128'({a, 8'd0, 3'd3, 2'd1, 4'd0, 3'd0, 4'd0, 4'd0, id, u});
  endfunction

  function automatic logic [127:0] mk_wdata(input logic [31:0] d, input logic [3:0] id);
    return 128'({d, 1'b1, id, 4'hF, 1'b0});
  endfunction

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    clks(8);
    so = tdo;
    tck = 1'b1;
    clks(8);
    tck = 1'b0;
  endtask

  task automatic tap_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic ir_shift(input logic [3:0] code, output logic [3:0] cap);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i]);
      cap[i] = so;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic dr_shift(input int n, input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = so;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  initial begin
    logic [127:0] o;
    logic [3:0]   ic;
    logic [127:0] a0, a1, wd, ar1, rv;
    logic [6:0]   bv;

    for (int p = 0; p < NP; p++) begin
      m_aw[p] = '0; m_w[p] = '0; m_ar[p] = '0;
    end
    clks(5);
    rst = 1'b0;
    clks(3);

    // R13 reset state, R10 ready while empty
    chk("R13 reset valids", 128'({aw_valid, w_valid, ar_valid}), 128'(0));
    chk("R10 reset ready", 128'({b_ready, r_ready}), 128'(4'b1111));
    chk("R4 reset tdo", 128'(tdo), 128'(0));

    tap_reset();

    // R2 bypass after reset: captured 0 then TDI delayed by one
    dr_shift(8, 128'(8'hB5), o);
    chk("R2 bypass", 128'(o[7:0]), 128'(8'h6A));

    // R1 capture pattern, load write-address code of port 0
    ir_shift(4'd0, ic);
    chk("R1 ir capture", 128'(ic), 128'(4'b0001));

    // R7 R5 first write-address beat on port 0
    a0 = mk_addr(32'h1000_0040, 4'h3, 1'b1);
    m_aw[0] = a0;
    dr_shift(AW_W, a0, o);
    chk("R7 aw valid", 128'(aw_valid), 128'(2'b01));
    chk("R5 aw payload", 128'(aw_bits[AW_W-1:0]), a0);

    // R8 second update while pending is ignored
    a1 = mk_addr(32'h2000_0080, 4'h9, 1'b0);
    dr_shift(AW_W, a1, o);
    chk("R8 aw ignored", 128'(aw_bits[AW_W-1:0]), a0);
    chk("R8 aw still valid", 128'(aw_valid), 128'(2'b01));

    // R9 one-clock ready ends the beat
    aw_ready[0] = 1'b1; clks(1); aw_ready[0] = 1'b0; clks(1);
    chk("R9 aw dropped", 128'(aw_valid), 128'(0));

    // R7 new beat accepted after the handshake
    m_aw[0] = a1;
    dr_shift(AW_W, a1, o);
    chk("R7 aw second", 128'(aw_bits[AW_W-1:0]), a1);
    aw_ready[0] = 1'b1; clks(1); aw_ready[0] = 1'b0; clks(1);

    // R3 R6 write data on port 1 (code 6)
    ir_shift(4'd6, ic);
    wd = mk_wdata(32'hDEAD_BEEF, 4'h5);
    m_w[1] = wd;
    dr_shift(W_W, wd, o);
    chk("R3 w port select", 128'({w_valid, aw_valid}), 128'(4'b1000));
    chk("R6 w payload", 128'(w_bits[2*W_W-1:W_W]), wd);

    // R3 R5 read address on port 1 (code 8), left pending
    ir_shift(4'd8, ic);
    ar1 = mk_addr(32'h0000_1234, 4'hC, 1'b1);
    m_ar[1] = ar1;
    dr_shift(AW_W, ar1, o);
    chk("R3 ar port select", 128'(ar_valid), 128'(2'b10));
    chk("R5 ar payload", 128'(ar_bits[2*AW_W-1:AW_W]), ar1);

    // R13 reset state drops pending valids
    tap_reset();
    chk("R13 tlr clears", 128'({aw_valid, w_valid, ar_valid}), 128'(0));

    // R10 R11 write response on port 0 (code 2)
    bv = {2'b10, 4'h3, 1'b1};
    b_bits[B_W-1:0] = bv;
    b_valid[0] = 1'b1; clks(1); b_valid[0] = 1'b0; clks(2);
    chk("R10 b ready low when full", 128'(b_ready), 128'(2'b10));
    ir_shift(4'd2, ic);
    dr_shift(B_W + 1, 128'(0), o);
    chk("R11 b capture", 128'(o[B_W:0]), 128'({1'b1, bv}));
    chk("R11 b freed", 128'(b_ready), 128'(2'b11));

    // R12 empty capture reads zeros
    dr_shift(B_W + 1, 128'(0), o);
    chk("R12 b empty", 128'(o[B_W:0]), 128'(0));

    // R11 R4 read data on port 1 (code 9)
    rv = 128'({2'b01, 32'hCAFE_F00D, 1'b1, 4'hA, 1'b0});
    r_bits[2*R_W-1:R_W] = rv[R_W-1:0];
    r_valid[1] = 1'b1; clks(1); r_valid[1] = 1'b0; clks(2);
    chk("R10 r ready low when full", 128'(r_ready), 128'(2'b01));
    ir_shift(4'd9, ic);
    dr_shift(R_W + 1, 128'(0), o);
    chk("R11 r capture", 128'(o[R_W:0]), 128'({1'b1, rv[R_W-1:0]}));

    // R2 unused code behaves as bypass and raises nothing
    ir_shift(4'd12, ic);
    dr_shift(4, 128'(4'b1011), o);
    chk("R2 unused code bypass", 128'(o[3:0]), 128'(4'b0110));
    chk("R2 no request raised", 128'({aw_valid, w_valid, ar_valid}), 128'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule